// File: doc/BRIEF.md
# Pattern Color Expansion Write Path

This block sits on the CPU write side of a pixel memory pipeline. When pattern mode is enabled, one CPU write byte is read as a monochrome mask: each of its bits picks either the foreground or the background color for one of eight pixels. All eight pixels are then presented together for writing. When pattern mode is disabled, the byte is forwarded as a single packed pixel.

Between the pixel source and the output there is a small function stage. It forwards either the pattern-derived source or the memory latch contents. Two independently programmable polarity stages can invert data. The first inverts the latch data on its way into the function stage. The second inverts the function stage result on its way to the output.

A planar-mode flag limits every output pixel to its low four bits. Every result is registered one cycle after the write strobe, together with a valid flag and a per-pixel write enable.

Top module: `cexp_write_path`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `out_valid` is 0, `pix_we` is 0 and `pix_data` is 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `wr_stb` high, and 0 otherwise. `pix_we` is all zeros whenever `out_valid` is 0.
- R3: With `expand_en`=1, pixel i (`pix_data[8*i+7:8*i]`) takes `fg_color` if `cpu_data[7-i]` is 1 and `bg_color` if it is 0, so bit 7 maps to pixel 0. `pix_we` is 8'hFF.
- R4: With `expand_en`=0, pixel 0 carries `cpu_data` and `pix_we` is 8'h01.
- R5: With `planar_mode`=1, bits 7..4 of every output pixel are 0 and the low 4 bits follow the other rules.
- R6: With `fn_use_latch`=1, pixel i carries latch pixel i (`latch_data[8*i+7:8*i]`), bitwise inverted when `lat_inv`=1.
- R7: With `fn_inv`=1, every pixel is the bitwise inverse of what it would be with `fn_inv`=0.
- R8: With `fn_use_latch`=0, `lat_inv` has no effect on `pix_data`.
- R9: In a cycle following one without `wr_stb`, `pix_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | CPU write strobe, one cycle per write |
| expand_en | input | 1 | 1: pattern color expansion, 0: single packed pixel |
| planar_mode | input | 1 | 1: limit pixels to their low 4 bits |
| lat_inv | input | 1 | Invert latch data into the function stage |
| fn_inv | input | 1 | Invert function stage output |
| fn_use_latch | input | 1 | Function stage forwards latch (1) or pattern source (0) |
| cpu_data | input | 8 | CPU write byte |
| fg_color | input | 8 | Foreground color |
| bg_color | input | 8 | Background color |
| latch_data | input | 64 | Latched memory contents, 8 pixels of 8 bits |
| out_valid | output | 1 | Registered result valid |
| pix_we | output | 8 | Per-pixel write enable |
| pix_data | output | 64 | Eight output pixels, pixel i at bits 8*i+7:8*i |

## Verification
The hardest case to reach is a combination of controls where one stage hides the effect of another. Examples are latch inversion while the function stage forwards the pattern, and output inversion together with planar masking, where a fault in stage order leaves the upper nibble wrong. Directed writes set each of these combinations with distinct foreground, background and latch values, so that each pixel tells apart which path it came from. A long run of random control and data words is then compared on every cycle against a behavioural model. That model reaches the remaining mixes, including writes spaced closely back to back.

// File: rtl/cexp_pkg.sv
package cexp_pkg;
  typedef enum logic {
    FN_SRC_PATTERN = 1'b0,
    FN_SRC_LATCH   = 1'b1
  } fn_src_e;
endpackage

// File: rtl/cexp_pattern_src.sv
module cexp_pattern_src #(
  parameter int NPIX    = 8,
  parameter int PIXW    = 8,
  parameter int PLANARW = 4
) (
  input  logic                 expand_en,
  input  logic                 planar_mode,
  input  logic [NPIX-1:0]      cpu_data,
  input  logic [PIXW-1:0]      fg_color,
  input  logic [PIXW-1:0]      bg_color,
  output logic [NPIX*PIXW-1:0] src_pix,
  output logic [NPIX-1:0]      src_we
);
  localparam logic [PIXW-1:0] PMASK = PIXW'((1 << PLANARW) - 1);

  logic [PIXW-1:0] fg_eff, bg_eff, cpu_eff;

  always_comb begin
    fg_eff  = planar_mode ? (fg_color & PMASK) : fg_color;
    bg_eff  = planar_mode ? (bg_color & PMASK) : bg_color;
    cpu_eff = planar_mode ? (PIXW'(cpu_data) & PMASK) : PIXW'(cpu_data);
  end

  for (genvar i = 0; i < NPIX; i++) begin : g_pix
    if (i == 0) begin : g_first
      assign src_pix[i*PIXW +: PIXW] = expand_en ?
        (cpu_data[NPIX-1-i] ? fg_eff : bg_eff) : cpu_eff;
      assign src_we[i] = 1'b1;
    end else begin : g_rest
      assign src_pix[i*PIXW +: PIXW] = expand_en ?
        (cpu_data[NPIX-1-i] ? fg_eff : bg_eff) : '0;
      assign src_we[i] = expand_en;
    end
  end
endmodule

// File: rtl/cexp_polarity.sv
module cexp_polarity #(
  parameter int W = 8
) (
  input  logic         inv,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  assign dout = inv ? ~din : din;
endmodule

// File: rtl/cexp_write_path.sv
module cexp_write_path #(
  parameter int NPIX    = 8,
  parameter int PIXW    = 8,
  parameter int PLANARW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_stb,
  input  logic                 expand_en,
  input  logic                 planar_mode,
  input  logic                 lat_inv,
  input  logic                 fn_inv,
  input  logic                 fn_use_latch,
  input  logic [NPIX-1:0]      cpu_data,
  input  logic [PIXW-1:0]      fg_color,
  input  logic [PIXW-1:0]      bg_color,
  input  logic [NPIX*PIXW-1:0] latch_data,
  output logic                 out_valid,
  output logic [NPIX-1:0]      pix_we,
  output logic [NPIX*PIXW-1:0] pix_data
);
  import cexp_pkg::*;

  localparam int              BUSW  = NPIX * PIXW;
  localparam logic [PIXW-1:0] PMASK = PIXW'((1 << PLANARW) - 1);

  logic [BUSW-1:0] src_pix, lat_pol, fn_res;
  logic [NPIX-1:0] src_we;
  fn_src_e         fn_sel;

  assign fn_sel = fn_use_latch ? FN_SRC_LATCH : FN_SRC_PATTERN;

  cexp_pattern_src #(.NPIX(NPIX), .PIXW(PIXW), .PLANARW(PLANARW)) u_src (
    .expand_en  (expand_en),
    .planar_mode(planar_mode),
    .cpu_data   (cpu_data),
    .fg_color   (fg_color),
    .bg_color   (bg_color),
    .src_pix    (src_pix),
    .src_we     (src_we)
  );

  cexp_polarity #(.W(BUSW)) u_lat_pol (
    .inv (lat_inv),
    .din (latch_data),
    .dout(lat_pol)
  );

  for (genvar i = 0; i < NPIX; i++) begin : g_fn
    logic [PIXW-1:0] fn_out, pol_out;
    assign fn_out = (fn_sel == FN_SRC_LATCH) ? lat_pol[i*PIXW +: PIXW]
                                             : src_pix[i*PIXW +: PIXW];
    cexp_polarity #(.W(PIXW)) u_fn_pol (
      .inv (fn_inv),
      .din (fn_out),
      .dout(pol_out)
    );
    assign fn_res[i*PIXW +: PIXW] = planar_mode ? (pol_out & PMASK) : pol_out;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      pix_we    <= '0;
      pix_data  <= '0;
    end else begin
      out_valid <= wr_stb;
      pix_we    <= wr_stb ? src_we : '0;
      if (wr_stb) pix_data <= fn_res;
    end
  end
endmodule

// File: rtl/cexp_write_path_chk.sv
module cexp_write_path_chk #(
  parameter int NPIX    = 8,
  parameter int PIXW    = 8,
  parameter int PLANARW = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_stb,
  input logic                 expand_en,
  input logic                 planar_mode,
  input logic                 out_valid,
  input logic [NPIX-1:0]      pix_we,
  input logic [NPIX*PIXW-1:0] pix_data
);
  localparam logic [PIXW-1:0]      PMASK = PIXW'((1 << PLANARW) - 1);
  localparam logic [NPIX*PIXW-1:0] UPPER = ~{NPIX{PMASK}};

  assert_reset_R1: assert property (@(posedge clk) rst |=> (!out_valid && pix_we == '0));
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst) wr_stb |=> out_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (rst) !wr_stb |=> !out_valid);
  assert_no_we_idle_R2: assert property (@(posedge clk) disable iff (rst) !out_valid |-> pix_we == '0);
  assert_expand_we_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && expand_en) |=> pix_we == '1);
  assert_packed_we_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !expand_en) |=> pix_we == NPIX'(1));
  assert_planar_upper_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && planar_mode) |=> (pix_data & UPPER) == '0);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(pix_data));
endmodule

bind cexp_write_path cexp_write_path_chk #(.NPIX(NPIX), .PIXW(PIXW), .PLANARW(PLANARW)) u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .expand_en(expand_en),
  .planar_mode(planar_mode), .out_valid(out_valid), .pix_we(pix_we), .pix_data(pix_data)
);

// File: tb/tb_cexp_write_path.sv
`timescale 1ns/1ps
module tb_cexp_write_path;
  logic        clk = 0, rst = 1;
  logic        wr_stb = 0, expand_en = 0, planar_mode = 0, lat_inv = 0, fn_inv = 0, fn_use_latch = 0;
  logic [7:0]  cpu_data = 0, fg_color = 0, bg_color = 0;
  logic [63:0] latch_data = 0;
  logic        out_valid;
  logic [7:0]  pix_we;
  logic [63:0] pix_data;

  int tests = 0, fails = 0;
  logic        exp_valid = 0;
  logic [7:0]  exp_we = 0;
  logic [63:0] exp_data = 0;
  string       exp_tag = "R1";

  always #5 clk = ~clk;

  cexp_write_path dut (.*);

  // behavioural reference
  function automatic logic [63:0] model_pixels();
    logic [63:0] r;
    for (int i = 0; i < 8; i++) begin
      int v;
      if (fn_use_latch) v = lat_inv ? (~latch_data[i*8 +: 8]) & 8'hFF : latch_data[i*8 +: 8];
      else if (expand_en) v = cpu_data[7-i] ? fg_color : bg_color;
      else v = (i == 0) ? cpu_data : 0;
      if (fn_inv) v = (~v) & 8'hFF;
      if (planar_mode) v = v % 16;
      r[i*8 +: 8] = 8'(v);
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      exp_valid <= 0; exp_we <= 0; exp_data <= 0; exp_tag <= "R1";
    end else begin
      exp_valid <= wr_stb;
      exp_we    <= wr_stb ? (expand_en ? 8'hFF : 8'h01) : 8'h00;
      if (wr_stb) exp_data <= model_pixels();
      exp_tag <= !wr_stb ? "R9" : fn_use_latch ? "R6" : fn_inv ? "R7" :
                 planar_mode ? "R5" : expand_en ? "R3" : "R4";
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    chk("R2", {55'd0, out_valid, pix_we}, {55'd0, exp_valid, exp_we});
    chk(exp_tag, pix_data, exp_data);
  end

  task automatic write(input logic e, p, li, fi, ul, input logic [7:0] c, f, b, input logic [63:0] l);
    expand_en = e; planar_mode = p; lat_inv = li; fn_inv = fi; fn_use_latch = ul;
    cpu_data = c; fg_color = f; bg_color = b; latch_data = l; wr_stb = 1;
    @(negedge clk); #1;
    wr_stb = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;
    @(negedge clk); #1;
    chk("R1", {out_valid, pix_we, pix_data}, 73'd0);

    write(1, 0, 0, 0, 0, 8'h80, 8'h5A, 8'h11, 64'h0);
    chk("R3", {pix_we, pix_data[15:0]}, {8'hFF, 16'h115A});
    chk("R3", pix_data[63:56], 8'h11);

    write(0, 0, 0, 0, 0, 8'hC3, 8'h5A, 8'h11, 64'h0);
    chk("R4", {pix_we, pix_data[7:0]}, {8'h01, 8'hC3});

    write(1, 1, 0, 0, 0, 8'h0F, 8'hFA, 8'hB7, 64'h0);
    chk("R5", {pix_data[7:0], pix_data[63:56]}, {8'h07, 8'h0A});

    write(1, 0, 1, 0, 1, 8'h00, 8'h00, 8'h00, 64'h0000_0000_3C00_0000);
    chk("R6", pix_data[31:24], 8'hC3);

    write(1, 0, 0, 1, 0, 8'hFF, 8'h0F, 8'h00, 64'h0);
    chk("R7", pix_data[7:0], 8'hF0);

    write(1, 0, 1, 0, 0, 8'hAA, 8'h12, 8'h34, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R8", pix_data[15:0], 16'h3412);

    @(negedge clk); #1;
    chk("R9", pix_data[15:0], 16'h3412);
    chk("R2", {63'd0, out_valid}, 64'd0);

    for (int n = 0; n < 400; n++) begin
      expand_en = 1'($urandom); planar_mode = 1'($urandom); lat_inv = 1'($urandom);
      fn_inv = 1'($urandom); fn_use_latch = 1'($urandom); wr_stb = 1'($urandom);
      cpu_data = 8'($urandom); fg_color = 8'($urandom); bg_color = 8'($urandom);
      latch_data = {32'($urandom), 32'($urandom)};
      @(negedge clk); #1;
    end
    wr_stb = 0;
    @(negedge clk); #1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule